// File: doc/BRIEF.md
# PHY Management Frame Master

This block runs one management transaction towards an Ethernet PHY over the two-wire management bus. The bus has a clock line, MDC, and a bidirectional data line, MDIO. The host programs a clock divisor. It then writes one 32-bit command word, which holds the start pattern, the operation code, the PHY and register addresses, the turnaround code and, for writes, the data. The engine first sends a preamble of 32 ones. It then shifts the command word out, most significant bit first. Each bit changes on a falling MDC edge, so the PHY can sample it on the rising edge.

For a read, the engine stops driving MDIO at the second turnaround bit. It then collects sixteen bits from the PHY. When the frame completes, those bits replace the low half of the command register. Completion sets a sticky event flag, which the host clears by writing a one to it. The line stays low and the engine stays idle while the divisor is zero. A command written while a frame is in flight is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy is low, MDC is low, MDIO is not driven (mdio_oe low), the event register reads zero and the command register reads zero.
- R2: A command write accepted while the engine is idle and the divisor is nonzero raises busy on the next cycle. Busy stays high for exactly 128 × divisor clock cycles, and falls in the same cycle that the done event is set.
- R3: On every rising MDC edge of a frame, the bench sees MDIO show one frame bit. The 64 bits are 32 ones followed by command bits 31 down to 0, in that order.
- R4: One MDC period is 2 × divisor system clocks. MDIO and its enable change only together with a falling MDC edge.
- R5: When bits 29:28 of the command equal binary 10 (read), mdio_oe is low from the frame position that carries command bit 16 to the end of the frame. For any other code, mdio_oe stays high for all 64 bits. Outside a frame, mdio_oe is low.
- R6: After a read, command bits 15:0 hold the sixteen MDIO samples, the first sample in bit 15. Each sample is taken in the last system cycle before the MDC rise of its bit. Bits 31:16 keep the value that was written. After a write operation, the register keeps the word that was written.
- R7: Frame completion sets event bit 23. A write with event bit 23 at one clears it, and a write with that bit at zero leaves it set. If a clear and a completion fall in the same cycle, the flag ends up set.
- R8: While the divisor is zero, MDC stays low, command writes are ignored and busy stays low.
- R9: A command write while busy is ignored. The frame in flight and the command register are unaffected.
- R10: The divisor is taken from bits 6:1 of the divisor write data, and bit 0 has no effect. Divisor writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word |
| spd_we | input | 1 | Write strobe for the divisor register |
| spd_wdata | input | 32 | Divisor write data, value in bits 6:1 |
| evt_we | input | 1 | Write strobe for the event register (write one to clear) |
| evt_wdata | input | 32 | Event clear mask |
| mdio_i | input | 1 | Sampled MDIO line |
| cmd_rdata | output | 32 | Command register, read data in bits 15:0 |
| evt_rdata | output | 32 | Event register, done flag in bit 23 |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that the divisor is steady while a frame runs, and the design enforces this by dropping divisor writes during busy. They also assume that the host never writes the command register in the cycle a frame ends. The stimulus writes the divisor only between frames. It uses divisors of 1 to 3 and random operation codes, addresses and data. It issues commands only when busy is low, except for one directed collision placed well inside a frame. The PHY model returns its data only on the sixteen data positions and leaves the line pulled high elsewhere.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W        = 32;
    localparam int DATA_W       = 16;
    localparam int EVT_W        = 32;
    localparam int EVT_DONE_BIT = 23;
    localparam int OP_HI        = 29;
    localparam int OP_LO        = 28;
    localparam int TA_LO_BIT    = 16;
    localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SPD_W-1:0] speed_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [SPD_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d  = gen_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!run_i || speed_i == '0) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (gen_q.cnt == speed_i - SPD_W'(1)) begin
            gen_d.cnt = '0;
            gen_d.mdc = !gen_q.mdc;
            rise_o    = !gen_q.mdc;
            fall_o    = gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + SPD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc_o = gen_q.mdc;

    // R8: the line rests low whenever the engine is not running
    p_mdc_rest_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || speed_i == '0) |=> !mdc_o);

    // R4: the half-period counter never passes the divisor
    p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && speed_i != '0) |-> (gen_q.cnt < speed_i));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CMD_W-1:0]  word_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_op_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int REL_POS   = PRE_LEN + CMD_W - 1 - TA_LO_BIT;
    localparam int DAT_POS   = REL_POS + 1;
    localparam int LAST_POS  = FRAME_LEN - 1;

    typedef struct packed {
        logic              busy;
        logic [POS_W-1:0]  pos;
        logic [CMD_W-1:0]  word;
        logic [DATA_W-1:0] rx;
        logic              mo;
        logic              oe;
    } eng_t;

    eng_t eng_d, eng_q;
    logic is_rd;
    int   nxt;

    function automatic logic stream_bit(input logic [CMD_W-1:0] w, input int p);
        if (p < PRE_LEN) return 1'b1;
        return w[CMD_W - 1 - (p - PRE_LEN)];
    endfunction

    assign is_rd = (eng_q.word[OP_HI:OP_LO] == OP_RD);

    always_comb begin
        eng_d  = eng_q;
        done_o = 1'b0;
        nxt    = int'(eng_q.pos) + 1;
        if (!eng_q.busy) begin
            if (start_i) begin
                eng_d.busy = 1'b1;
                eng_d.pos  = '0;
                eng_d.word = word_i;
                eng_d.rx   = '0;
                eng_d.mo   = stream_bit(word_i, 0);
                eng_d.oe   = 1'b1;
            end
        end else begin
            if (rise_i && is_rd && int'(eng_q.pos) >= DAT_POS)
                eng_d.rx = {eng_q.rx[DATA_W-2:0], mdio_i};
            if (fall_i) begin
                if (int'(eng_q.pos) == LAST_POS) begin
                    eng_d.busy = 1'b0;
                    eng_d.oe   = 1'b0;
                    eng_d.mo   = 1'b1;
                    done_o     = 1'b1;
                end else begin
                    eng_d.pos = eng_q.pos + POS_W'(1);
                    eng_d.mo  = stream_bit(eng_q.word, nxt);
                    eng_d.oe  = !(is_rd && nxt >= REL_POS);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.mo   <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o    = eng_q.busy;
    assign rd_op_o   = is_rd;
    assign rd_data_o = eng_q.rx;
    assign mdio_o    = eng_q.mo;
    assign mdio_oe_o = eng_q.oe;

    // R3: preamble positions always drive a one
    p_preamble_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && int'(eng_q.pos) < PRE_LEN) |-> (mdio_o && mdio_oe_o));

    // R4: the line only moves together with a falling MDC edge
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && $past(eng_q.busy) && !$past(fall_i))
            |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R5: read frames release the line from the second turnaround bit on
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && is_rd && int'(eng_q.pos) >= REL_POS) |-> !mdio_oe_o);

    // R5: other frames drive every bit, and idle never drives
    p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.busy && !is_rd) |-> mdio_oe_o);
    p_idle_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.busy |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    input  logic        spd_we,
    input  logic [31:0] spd_wdata,
    input  logic        evt_we,
    input  logic [31:0] evt_wdata,
    input  logic        mdio_i,
    output logic [31:0] cmd_rdata,
    output logic [31:0] evt_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [SPD_W-1:0] spd;
        logic             evt;
    } regs_t;

    regs_t regs_d, regs_q;
    logic accept, eng_busy, eng_done, eng_rd, rise, fall;
    logic [DATA_W-1:0] eng_rx;

    assign accept = cmd_we && !eng_busy && (regs_q.spd != '0);

    always_comb begin
        regs_d = regs_q;
        if (accept)
            regs_d.cmd = cmd_wdata;
        if (spd_we && !eng_busy)
            regs_d.spd = spd_wdata[SPD_W:1];
        if (evt_we && evt_wdata[EVT_DONE_BIT])
            regs_d.evt = 1'b0;
        if (eng_done) begin
            regs_d.evt = 1'b1;
            if (eng_rd)
                regs_d.cmd[DATA_W-1:0] = eng_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (eng_busy),
        .speed_i (regs_q.spd),
        .mdc_o   (mdc),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .word_i    (cmd_wdata),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .rd_op_o   (eng_rd),
        .rd_data_o (eng_rx),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    always_comb begin
        evt_rdata               = '0;
        evt_rdata[EVT_DONE_BIT] = regs_q.evt;
    end

    assign cmd_rdata = regs_q.cmd;
    assign busy      = eng_busy;

    // R2/R7: the end of busy always leaves the done flag set
    p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt_rdata[EVT_DONE_BIT]);

    // R9: the command word written for the frame is not overwritten mid-flight
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(regs_q.cmd[CMD_W-1:DATA_W]));

    // R8: a zero divisor never coexists with a running frame
    p_zero_spd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.spd == '0) |-> !busy);

    // R10: the divisor stays fixed while a frame runs
    p_spd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(regs_q.spd));
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0, spd_we = 1'b0, evt_we = 1'b0;
    logic [31:0] cmd_wdata = '0, spd_wdata = '0, evt_wdata = '0;
    logic        mdio_i;
    logic [31:0] cmd_rdata, evt_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;

    int tests = 0, fails = 0;
    int cyc = 0, k = 0, base = 0;
    logic [15:0] phy_word = '0;
    logic rec_o  [0:63];
    logic rec_oe [0:63];
    int   rise_cyc [0:63];

    always #2.5 clk = ~clk;

    mdio_mgmt_master u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .spd_we(spd_we), .spd_wdata(spd_wdata),
        .evt_we(evt_we), .evt_wdata(evt_wdata),
        .mdio_i(mdio_i), .cmd_rdata(cmd_rdata), .evt_rdata(evt_rdata),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    function automatic logic phy_bit(input logic [15:0] pw, input int j);
        if (j >= 48 && j < 64) return pw[63 - j];
        return 1'b1;
    endfunction

    assign mdio_i = phy_bit(phy_word, k - base);

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        int j;
        j = k - base;
        if (j >= 0 && j < 64) begin
            rec_o[j]    = mdio_o;
            rec_oe[j]   = mdio_oe;
            rise_cyc[j] = cyc;
        end
        k = k + 1;
    end

    function automatic logic exp_bit(input logic [31:0] w, input int j);
        if (j < 32) return 1'b1;
        return w[63 - j];
    endfunction

    function automatic logic exp_oe(input logic [31:0] w, input int j);
        return !(w[29:28] == 2'b10 && j >= 47);
    endfunction

    function automatic logic [31:0] exp_reg(input logic [31:0] w, input logic [15:0] pw);
        if (w[29:28] == 2'b10) return {w[31:16], pw};
        return w;
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_speed(input int v, input logic b0);
        spd_we = 1'b1; spd_wdata = (32'(v) << 1) | 32'(b0);
        @(negedge clk);
        spd_we = 1'b0;
    endtask

    task automatic clr_evt(input logic [31:0] m);
        evt_we = 1'b1; evt_wdata = m;
        @(negedge clk);
        evt_we = 1'b0; evt_wdata = '0;
    endtask

    // mode 0: plain, 1: extra writes while busy (R9/R10), 2: clear collides with done (R7)
    task automatic run_frame(input logic [31:0] w, input logic [15:0] pw, input int spd, input int mode);
        int c, bad_o, bad_oe, lim;
        phy_word = pw;
        base = k;
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        check(busy == 1'b1, "R2 busy after write", busy, 1);
        c = 0;
        lim = 128 * spd + 50;
        while (busy && c < lim) begin
            cmd_we = 1'b0; spd_we = 1'b0; evt_we = 1'b0;
            if (mode == 1 && c == 10) begin
                cmd_we = 1'b1; cmd_wdata = ~w;
                spd_we = 1'b1; spd_wdata = 32'h0000_0020;
            end
            if (mode == 2 && c == 128 * spd - 1) begin
                evt_we = 1'b1; evt_wdata = 32'h0080_0000;
            end
            @(negedge clk);
            c++;
        end
        cmd_we = 1'b0; spd_we = 1'b0; evt_we = 1'b0; evt_wdata = '0;
        check(c == 128 * spd, "R2 busy length", c, 128 * spd);
        check(k - base == 64, "R3 rise count", k - base, 64);
        bad_o = 0; bad_oe = 0;
        for (int j = 0; j < 64; j++) begin
            if (rec_oe[j] != exp_oe(w, j)) bad_oe++;
            if (exp_oe(w, j) && rec_o[j] != exp_bit(w, j)) bad_o++;
        end
        check(bad_o == 0, "R3 bit stream mismatches", bad_o, 0);
        check(bad_oe == 0, "R5 drive enable mismatches", bad_oe, 0);
        check(rise_cyc[1] - rise_cyc[0] == 2 * spd, "R4 first period",
              rise_cyc[1] - rise_cyc[0], 2 * spd);
        check(rise_cyc[63] - rise_cyc[62] == 2 * spd, "R4 R10 last period",
              rise_cyc[63] - rise_cyc[62], 2 * spd);
        check(cmd_rdata == exp_reg(w, pw), "R6 R9 command register", cmd_rdata, exp_reg(w, pw));
        check(evt_rdata == 32'h0080_0000, "R7 done flag", evt_rdata, 32'h0080_0000);
        check(mdio_oe == 1'b0, "R5 idle float", mdio_oe, 0);
        clr_evt(32'h0080_0000);
    endtask

    initial begin
        logic [31:0] w, held;
        int spd;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && mdc == 0 && mdio_oe == 0, "R1 idle outputs", {busy, mdc, mdio_oe}, 0);
        check(evt_rdata == 0 && cmd_rdata == 0, "R1 registers", cmd_rdata | evt_rdata, 0);

        // R8: zero divisor ignores commands
        cmd_we = 1'b1; cmd_wdata = 32'h5A5A_1234;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (20) begin
            @(negedge clk);
            check(busy == 0 && mdc == 0, "R8 idle with zero divisor", {busy, mdc}, 0);
        end
        check(cmd_rdata == 0, "R8 command ignored", cmd_rdata, 0);

        // directed read and write frames, bit 0 of divisor set (R10)
        wr_speed(2, 1'b1);
        run_frame(32'h6082_0000 | 32'h0000_0000, 16'hA5C3, 2, 0);
        run_frame(32'h5086_BEEF, 16'h1234, 2, 0);
        // R9/R10: writes during busy dropped
        wr_speed(1, 1'b0);
        run_frame(32'h6123_0000, 16'h0F0F, 1, 1);
        // R7: clear and completion in the same cycle leaves the flag set
        run_frame(32'h5002_FFFF, 16'h0000, 1, 2);

        // R7: a clear mask without bit 23 leaves the flag alone
        run_frame(32'h6002_0000, 16'h8001, 1, 0);
        // the frame task already cleared; raise it again
        cmd_we = 1'b1; cmd_wdata = 32'h5002_0001; @(negedge clk); cmd_we = 1'b0;
        while (busy) @(negedge clk);
        clr_evt(32'hFF7F_FFFF);
        check(evt_rdata[23] == 1'b1, "R7 clear without bit 23", evt_rdata[23], 1);
        clr_evt(32'h0080_0000);
        check(evt_rdata[23] == 1'b0, "R7 clear with bit 23", evt_rdata[23], 0);

        // random frames
        for (int i = 0; i < 10; i++) begin
            spd = 1 + int'($urandom_range(2));
            wr_speed(spd, 1'($urandom_range(1)));
            w = $urandom;
            w[31:30] = 2'b01;
            w[29:28] = ($urandom_range(1) == 1) ? 2'b10 : 2'b01;
            w[17:16] = 2'b10;
            run_frame(w, 16'($urandom), spd, 0);
        end

        // R8: divisor back to zero, command ignored, register unchanged
        held = cmd_rdata;
        wr_speed(0, 1'b1);
        cmd_we = 1'b1; cmd_wdata = 32'h6000_0000; @(negedge clk); cmd_we = 1'b0;
        repeat (10) @(negedge clk);
        check(busy == 0 && cmd_rdata == held, "R8 ignored after zero divisor", cmd_rdata, held);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule